// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block models a synchronous, single-port burst SRAM with 32-bit words split into four byte lanes, seen from its pin side. It registers every control input on the rising clock edge. From the registered controls it decides when an access begins, whether that access reads or writes, which bytes a write changes, and when the output data may be driven. Read data passes through an output register. A read whose address is captured at one edge therefore presents its data after the following edge.

An access can be opened by either of two active-low strobes, and the two differ in how writes are timed.

- The processor strobe always opens with a read-style cycle. It takes no notice of the write controls or the advance input in that cycle. The write, if any, lands on the next edge.
- The controller strobe writes in the same cycle it opens.

After an access opens, cycles with no strobe continue the access. They either hold the current address or step it through a four-beat wrapping burst. The burst order is interleaved or linear, chosen by an input pin.

The bus is not modelled as a tri-state pin. The block has a data input, a data output and a drive-enable output. The drive enable is built from a registered permission gated combinationally by an asynchronous, active-low output enable.

Top module: `bsram_ctrl`

## Requirements
- R1: A read issued at clock edge k puts the addressed word on `dout` and raises `dout_en` after edge k+1, provided `oe_n` is low and edge k+1 is neither a write nor a deselect.
- R2: A new access opens at an edge only when all three enables are active (`ce1_n`=0, `ce2`=1, `ce3_n`=0) and a strobe is low. With `gw_n`=1 and `bwe_n`=1 the access is a read. A strobe with any enable inactive opens nothing.
- R3: `ps_n` has no effect while `ce1_n` is high. An ongoing access continues as if no strobe were present.
- R4: An access opened by `ps_n` ignores `gw_n`, `bwe_n`, `bws_n` and `adv_n` at its opening edge. A write to the captured address happens at the next edge, using the write controls present at that edge.
- R5: An access opened by `cs_n` (with `ps_n` high or gated off) and active write controls writes at that same edge. `adv_n` is ignored at that edge.
- R6: `gw_n`=0 writes all four lanes whatever the byte controls are. Otherwise, `bwe_n`=0 writes lane i (bits 8i+7..8i) exactly when `bws_n[i]`=0. Lanes that are not written keep their contents.
- R7: With `lin_mode`=0 (interleaved), burst beat c reads word offset start XOR c. The offset wraps within the aligned group of four words.
- R8: With `lin_mode`=1 (linear), burst beat c reads word offset (start + c) mod 4.
- R9: In a continue cycle, `adv_n`=0 steps to the next burst beat and `adv_n`=1 repeats the current address.
- R10: A deselecting edge (a live strobe while an enable is inactive) drops `dout_en` right after that edge. `dout_en` is also low during the first cycle after an access opens from the deselected state.
- R11: After any edge that performs a write, `dout_en` is low whatever the value of `oe_n`.
- R12: `oe_n`=1 forces `dout_en` low without waiting for a clock edge.
- R13: Address bits at and above `DEPTH_LOG2` are ignored. Addresses that differ only in those bits reach the same word.
- R14: While `rst` is high, and after it is released, the block is deselected and `dout_en` is low until a read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Word address |
| ps_n | input | 1 | Processor address strobe, active low, gated by `ce1_n` |
| cs_n | input | 1 | Controller address strobe, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bws_n | input | 4 | Per-lane byte write selects, active low |
| adv_n | input | 1 | Burst advance, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| lin_mode | input | 1 | Burst order: 1 linear, 0 interleaved |
| din | input | 32 | Write data |
| dout | output | 32 | Registered read data |
| dout_en | output | 1 | Drive enable for `dout` |

## Verification
Two functions can fall on the same edge: the output register holding a read that was launched one edge earlier, and a write that must silence the bus. The bench provokes this collision in two ways, each with `oe_n` held low:

- It opens a processor-strobe access and follows it directly with its second-edge byte write.
- It drives a controller-strobe write on the edge right after a streaming read.

In both cases `dout_en` must be low after the colliding edge. Later reads must show that the write merged only the selected lanes, and that the write controls presented with the processor strobe were ignored.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int LANE_W  = 8;
  localparam int BURST_W = 2;

  typedef enum logic {
    ORDER_INTERLEAVED = 1'b0,
    ORDER_LINEAR      = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bsram_burst.sv
module bsram_burst
  import bsram_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [CW-1:0] start_i,
  input  logic         step_i,
  input  burst_order_e order_i,
  output logic [CW-1:0] cur_o,
  output logic [CW-1:0] nxt_o
);
  logic [CW-1:0] start_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      start_q <= start_i;
      cnt_q   <= '0;
    end else if (step_i) begin
      cnt_q   <= cnt_inc;
    end
  end

  always_comb begin
    if (order_i == ORDER_LINEAR) begin
      cur_o = start_q + cnt_q;
      nxt_o = start_q + cnt_inc;
    end else begin
      cur_o = start_q ^ cnt_q;
      nxt_o = start_q ^ cnt_inc;
    end
  end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic               clk,
  input  logic               en_i,
  input  logic               we_i,
  input  logic [LANES-1:0]   be_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [LANES*LW-1:0] wdata_i,
  output logic [LANES*LW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (en_i) begin
        if (we_i && be_i[g]) begin
          mem[addr_i] <= wdata_i[g*LW +: LW];
        end
        rd_q <= mem[addr_i];
      end
    end

    assign rdata_o[g*LW +: LW] = rd_q;
  end
endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       ps_n,
  input  logic                       cs_n,
  input  logic                       ce1_n,
  input  logic                       ce2,
  input  logic                       ce3_n,
  input  logic                       gw_n,
  input  logic                       bwe_n,
  input  logic [DATA_W/LANE_W-1:0]   bws_n,
  input  logic                       adv_n,
  input  logic                       oe_n,
  input  logic                       lin_mode,
  input  logic [DATA_W-1:0]          din,
  output logic [DATA_W-1:0]          dout,
  output logic                       dout_en
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int HI_W  = DEPTH_LOG2 - BURST_W;

  // Select and strobe decode
  logic sel_all;
  logic ps_live;
  logic cs_live;
  logic strobe;
  logic desel;
  logic ps_start;
  logic cs_start;
  logic start;
  logic cont;
  logic wr_req;
  logic do_write;
  logic do_read;
  logic step;

  logic                  active_q;
  logic [HI_W-1:0]       hi_q;
  logic                  rd_pend_q;
  logic                  drv_q;
  logic [DATA_W-1:0]     dout_q;

  logic [BURST_W-1:0]    cur_lo;
  logic [BURST_W-1:0]    nxt_lo;
  logic [BURST_W-1:0]    acc_lo;
  logic [HI_W-1:0]       acc_hi;
  logic [DEPTH_LOG2-1:0] acc_addr;
  logic [LANES-1:0]      lane_we;
  logic [DATA_W-1:0]     rdata;
  burst_order_e          order;

  logic unused_hi_bits;
  assign unused_hi_bits = ^addr[ADDR_W-1:DEPTH_LOG2];

  assign sel_all  = !ce1_n && ce2 && !ce3_n;
  assign ps_live  = !ps_n && !ce1_n;
  assign cs_live  = !cs_n;
  assign strobe   = ps_live || cs_live;
  assign desel    = strobe && !sel_all;
  assign ps_start = ps_live && sel_all;
  assign cs_start = cs_live && !ps_live && sel_all;
  assign start    = ps_start || cs_start;
  assign cont     = !strobe && active_q;
  assign wr_req   = !gw_n || !bwe_n;

  // Processor-strobe opening ignores write controls; writes land on a continue edge
  assign do_write = (cs_start || cont) && wr_req;
  assign do_read  = ps_start || ((cs_start || cont) && !wr_req);
  assign step     = cont && !adv_n;

  for (genvar g = 0; g < LANES; g++) begin : g_we
    assign lane_we[g] = !gw_n || (!bwe_n && !bws_n[g]);
  end

  assign order = lin_mode ? ORDER_LINEAR : ORDER_INTERLEAVED;

  bsram_burst #(
    .CW (BURST_W)
  ) u_burst (
    .clk     (clk),
    .rst     (rst),
    .load_i  (start),
    .start_i (addr[BURST_W-1:0]),
    .step_i  (step),
    .order_i (order),
    .cur_o   (cur_lo),
    .nxt_o   (nxt_lo)
  );

  always_comb begin
    if (start) begin
      acc_lo = addr[BURST_W-1:0];
      acc_hi = addr[DEPTH_LOG2-1:BURST_W];
    end else begin
      acc_lo = step ? nxt_lo : cur_lo;
      acc_hi = hi_q;
    end
  end

  assign acc_addr = {acc_hi, acc_lo};

  bsram_array #(
    .AW    (DEPTH_LOG2),
    .LANES (LANES),
    .LW    (LANE_W)
  ) u_array (
    .clk     (clk),
    .en_i    (do_read || do_write),
    .we_i    (do_write),
    .be_i    (lane_we),
    .addr_i  (acc_addr),
    .wdata_i (din),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      hi_q      <= '0;
      rd_pend_q <= 1'b0;
      drv_q     <= 1'b0;
      dout_q    <= '0;
    end else begin
      if (start) begin
        active_q <= 1'b1;
        hi_q     <= addr[DEPTH_LOG2-1:BURST_W];
      end else if (desel) begin
        active_q <= 1'b0;
      end
      rd_pend_q <= do_read;
      if (rd_pend_q) begin
        dout_q <= rdata;
      end
      drv_q <= rd_pend_q && !do_write && !desel;
    end
  end

  assign dout    = dout_q;
  assign dout_en = drv_q && !oe_n;
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          dout_en,
  input logic          ce1_n,
  input logic          cs_n,
  input logic          do_write,
  input logic          do_read,
  input logic          desel,
  input logic          start,
  input logic          active_q,
  input logic [BW-1:0] ld_lo,
  input logic [BW-1:0] cur_lo
);
  p_write_quiets_r11: assert property (@(posedge clk) disable iff (rst)
    do_write |=> !dout_en);

  p_desel_quiets_r10: assert property (@(posedge clk) disable iff (rst)
    desel |=> !dout_en);

  p_first_cycle_off_r10: assert property (@(posedge clk) disable iff (rst)
    (start && !active_q) |=> !dout_en);

  p_drive_follows_read_r1: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> $past(do_read));

  p_ps_gated_r3: assert property (@(posedge clk) disable iff (rst)
    (ce1_n && cs_n) |=> $stable(active_q));

  p_burst_start_r7: assert property (@(posedge clk) disable iff (rst)
    start |=> (cur_lo == $past(ld_lo)));
endmodule

bind bsram_ctrl bsram_chk #(.BW(2)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .dout_en  (dout_en),
  .ce1_n    (ce1_n),
  .cs_n     (cs_n),
  .do_write (do_write),
  .do_read  (do_read),
  .desel    (desel),
  .start    (start),
  .active_q (active_q),
  .ld_lo    (addr[1:0]),
  .cur_lo   (cur_lo)
);

// File: tb/bsram_ctrl_tb.sv
module bsram_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] addr;
  logic        ps_n, cs_n, ce1_n, ce2, ce3_n;
  logic        gw_n, bwe_n, adv_n, oe_n, lin_mode;
  logic [3:0]  bws_n;
  logic [31:0] din;
  logic [31:0] dout;
  logic        dout_en;

  logic [31:0] ref_mem [256];
  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bsram_ctrl u_dut (
    .clk(clk), .rst(rst), .addr(addr), .ps_n(ps_n), .cs_n(cs_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bws_n(bws_n), .adv_n(adv_n), .oe_n(oe_n), .lin_mode(lin_mode),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (ok !== 1'b1) begin
      nbad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_idle();
    ps_n = 1'b1; cs_n = 1'b1; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    gw_n = 1'b1; bwe_n = 1'b1; bws_n = 4'hF; adv_n = 1'b1;
  endtask

  task automatic deselect();
    set_idle();
    cs_n = 1'b0; ce2 = 1'b0;
    tick();
    set_idle();
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic g, input logic b, input logic [3:0] s);
    logic [31:0] r = old;
    if (!g) r = d;
    else if (!b) begin
      for (int i = 0; i < 4; i++) if (!s[i]) r[i*8 +: 8] = d[i*8 +: 8];
    end
    return r;
  endfunction

  task automatic cs_write(input logic [15:0] a, input logic [31:0] d,
                          input logic g, input logic b, input logic [3:0] s,
                          input logic adv);
    set_idle();
    cs_n = 1'b0; addr = a; din = d; gw_n = g; bwe_n = b; bws_n = s; adv_n = adv;
    tick();
    ref_mem[a[7:0]] = merge(ref_mem[a[7:0]], d, g, b, s);
    deselect();
  endtask

  task automatic rd_check(input logic [15:0] a, input string req);
    set_idle();
    cs_n = 1'b0; addr = a;
    tick();
    chk(dout_en == 1'b0, "R10", "first cycle undriven", 32'(dout_en), 32'h0);
    set_idle();
    tick();
    chk(dout_en == 1'b1, req, "read drive", 32'(dout_en), 32'h1);
    chk(dout == ref_mem[a[7:0]], req, "read data", dout, ref_mem[a[7:0]]);
    deselect();
  endtask

  task automatic t_reset();
    set_idle(); oe_n = 1'b0; lin_mode = 1'b0; addr = '0; din = '0;
    rst = 1'b1;
    repeat (3) tick();
    chk(dout_en == 1'b0, "R14", "in reset", 32'(dout_en), 32'h0);
    rst = 1'b0;
    tick();
    chk(dout_en == 1'b0, "R14", "after reset", 32'(dout_en), 32'h0);
  endtask

  task automatic t_basic_rw();
    cs_write(16'h0003, 32'h12345678, 1'b0, 1'b1, 4'hF, 1'b1);
    cs_write(16'h0004, 32'h9ABCDEF0, 1'b1, 1'b0, 4'h0, 1'b1);
    rd_check(16'h0003, "R1");
    rd_check(16'h0004, "R2");
  endtask

  task automatic t_lanes();
    cs_write(16'h0005, 32'hAABBCCDD, 1'b0, 1'b1, 4'hF, 1'b1);
    cs_write(16'h0005, 32'h11223344, 1'b1, 1'b0, 4'b1010, 1'b1);
    rd_check(16'h0005, "R6");
    chk(ref_mem[5] == 32'hAA22CC44, "R6", "model lanes", ref_mem[5], 32'hAA22CC44);
    cs_write(16'h0006, 32'h0F0F0F0F, 1'b0, 1'b1, 4'hF, 1'b1);
    cs_write(16'h0006, 32'hF0E0D0C0, 1'b0, 1'b0, 4'b1110, 1'b1);
    rd_check(16'h0006, "R6");
    cs_write(16'h0006, 32'h55555555, 1'b1, 1'b0, 4'hF, 1'b1);
    rd_check(16'h0006, "R6");
  endtask

  task automatic t_cs_adv();
    cs_write(16'h0009, 32'h99999999, 1'b0, 1'b1, 4'hF, 1'b1);
    cs_write(16'h0008, 32'h88888888, 1'b0, 1'b1, 4'hF, 1'b0);
    rd_check(16'h0008, "R5");
    rd_check(16'h0009, "R5");
  endtask

  task automatic t_ps_write();
    cs_write(16'h0030, 32'h01020304, 1'b0, 1'b1, 4'hF, 1'b1);
    cs_write(16'h0031, 32'h0A0B0C0D, 1'b0, 1'b1, 4'hF, 1'b1);
    set_idle();
    ps_n = 1'b0; addr = 16'h0030; gw_n = 1'b0; din = 32'hDEADBEEF; adv_n = 1'b0;
    tick();
    ps_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b0; bws_n = 4'b1110;
    din = 32'h55667788; adv_n = 1'b1;
    tick();
    chk(dout_en == 1'b0, "R11", "ps write edge", 32'(dout_en), 32'h0);
    ref_mem[8'h30] = merge(ref_mem[8'h30], 32'h55667788, 1'b1, 1'b0, 4'b1110);
    deselect();
    rd_check(16'h0030, "R4");
    rd_check(16'h0031, "R4");
  endtask

  task automatic t_burst(input logic lin, input logic [7:0] base, input logic [1:0] s,
                         input string req);
    for (int i = 0; i < 4; i++)
      cs_write(16'(base + i), 32'hB0000000 | (32'(base) << 8) | i, 1'b0, 1'b1, 4'hF, 1'b1);
    lin_mode = lin;
    set_idle();
    cs_n = 1'b0; addr = 16'(base + s);
    tick();
    set_idle();
    adv_n = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      logic [1:0] c = 2'(i - 1);
      logic [1:0] off = lin ? s + c : s ^ c;
      tick();
      chk(dout_en == 1'b1 && dout == ref_mem[base + off], req, "burst beat",
          dout, ref_mem[base + off]);
    end
    adv_n = 1'b1;
    begin
      logic [1:0] off1 = lin ? s + 2'd1 : s ^ 2'd1;
      tick();
      chk(dout == ref_mem[base + off1], "R9", "hold beat", dout, ref_mem[base + off1]);
      tick();
      chk(dout == ref_mem[base + off1], "R9", "hold again", dout, ref_mem[base + off1]);
    end
    deselect();
    lin_mode = 1'b0;
  endtask

  task automatic t_ps_gate();
    cs_write(16'h0020, 32'h20202020, 1'b0, 1'b1, 4'hF, 1'b1);
    set_idle();
    cs_n = 1'b0; addr = 16'h0020;
    tick();
    set_idle();
    tick();
    ps_n = 1'b0; ce1_n = 1'b1; addr = 16'h0055;
    tick();
    chk(dout_en == 1'b1 && dout == ref_mem[8'h20], "R3", "ps gated", dout, ref_mem[8'h20]);
    set_idle();
    ps_n = 1'b0; ce2 = 1'b0;
    tick();
    chk(dout_en == 1'b0, "R10", "ps deselect", 32'(dout_en), 32'h0);
    set_idle();
    tick();
  endtask

  task automatic t_oe();
    set_idle();
    cs_n = 1'b0; addr = 16'h0020;
    tick();
    set_idle();
    tick();
    oe_n = 1'b1;
    #1;
    chk(dout_en == 1'b0, "R12", "oe high", 32'(dout_en), 32'h0);
    oe_n = 1'b0;
    #1;
    chk(dout_en == 1'b1, "R12", "oe low", 32'(dout_en), 32'h1);
    deselect();
  endtask

  task automatic t_alias();
    cs_write(16'h0105, 32'hC0FFEE01, 1'b0, 1'b1, 4'hF, 1'b1);
    rd_check(16'h0005, "R13");
    chk(ref_mem[5] == 32'hC0FFEE01, "R13", "alias model", ref_mem[5], 32'hC0FFEE01);
  endtask

  task automatic t_write_kill();
    cs_write(16'h0040, 32'h40404040, 1'b0, 1'b1, 4'hF, 1'b1);
    set_idle();
    cs_n = 1'b0; addr = 16'h0040;
    tick();
    set_idle();
    tick();
    chk(dout_en == 1'b1, "R1", "stream drive", 32'(dout_en), 32'h1);
    cs_n = 1'b0; addr = 16'h0041; gw_n = 1'b0; din = 32'h41414141;
    tick();
    chk(dout_en == 1'b0, "R11", "write after read", 32'(dout_en), 32'h0);
    ref_mem[8'h41] = 32'h41414141;
    deselect();
    rd_check(16'h0041, "R5");
  endtask

  task automatic t_disabled();
    set_idle();
    cs_n = 1'b0; ce3_n = 1'b1; addr = 16'h0020;
    tick();
    set_idle();
    tick();
    chk(dout_en == 1'b0, "R2", "ce3 inactive", 32'(dout_en), 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = '0;
    t_reset();
    t_basic_rw();
    t_lanes();
    t_cs_adv();
    t_ps_write();
    t_burst(1'b0, 8'h10, 2'd1, "R7");
    t_burst(1'b1, 8'h14, 2'd2, "R8");
    t_burst(1'b0, 8'h18, 2'd3, "R7");
    t_ps_gate();
    t_oe();
    t_alias();
    t_write_kill();
    t_disabled();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nbad++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule